// File: doc/BRIEF.md
# Two-Level Instruction Control Decoder

This block is the purely combinational control unit of a single-cycle processor datapath. It receives the 6-bit opcode and the 6-bit function field of the current instruction. From these it produces every datapath steering signal: register destination choice, ALU operand source, load-to-register path, register-file write enable, data-memory write enable, branch, jump, immediate extension mode and a 3-bit ALU operation code.

Decoding takes two stages. A primary decoder turns the opcode into the steering signals and into a compact 3-bit intermediate ALU class. A secondary decoder, placed next to the ALU, combines that class with the function field to choose the final ALU operation. The function field only matters for register-register instructions. Any opcode outside the supported set yields outputs that write nothing.

The block has no clock and no state. There is no stream traffic at its edge, so every pin is a plain level signal that takes effect in the same cycle.

Top module: `opctl_decoder`

## Requirements
- R1: `reg_we` is 1 for opcodes 000000 (register-register), 001101 (or-immediate) and 100011 (load), and 0 for 101011 (store), 000100 (branch-if-equal) and 000010 (jump).
- R2: `dst_rd` is 1 only for opcode 000000. `load_to_reg` is 1 only for opcode 100011. `mem_we` is 1 only for opcode 101011.
- R3: `src_imm` is 1 for opcodes 001101, 100011 and 101011, and 0 for 000000, 000100 and 000010.
- R4: `ext_signed` is 0 (zero-extend) for opcode 001101 and 1 (sign-extend) for every other opcode.
- R5: `branch` is 1 only for opcode 000100, and `jump` is 1 only for opcode 000010.
- R6: For supported non-register-register opcodes, `alu_ctl` is 001 (or) for 001101, 110 (subtract) for 000100, and 010 (add) for 100011, 101011 and 000010.
- R7: For opcode 000000, `alu_ctl` follows the function field: 100000 gives 010 (add), 100010 gives 110 (subtract), 100100 gives 000 (and), 100101 gives 001 (or), 101010 gives 111 (set-on-less-than).
- R8: For opcode 000000 with any other function value, `alu_ctl` is 010 (add).
- R9: For any opcode other than 000000, the function field has no effect on any output.
- R10: For any unsupported opcode, every output is 0 except `ext_signed`, which is 1, and `alu_ctl`, which is 010.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_code | input | 6 | Instruction opcode field |
| fn_code | input | 6 | Instruction function field (register-register only) |
| dst_rd | output | 1 | 1: write the third register field, 0: the second |
| src_imm | output | 1 | 1: ALU operand B is the extended immediate |
| load_to_reg | output | 1 | 1: register write data comes from data memory |
| reg_we | output | 1 | Register file write enable |
| mem_we | output | 1 | Data memory write enable |
| branch | output | 1 | Conditional branch on equality |
| jump | output | 1 | Unconditional jump |
| ext_signed | output | 1 | 1: sign-extend the immediate, 0: zero-extend |
| alu_ctl | output | 3 | ALU operation code |

## Verification
The hardest case to reach from the ports is a function field that has no effect. This covers a non-register-register opcode that carries a function value which would select a different ALU operation, and it covers an unsupported opcode that sits next to a legal one. The stimulus pairs each opcode with conflicting function values. It then sweeps all 64 opcodes with a fixed function value and all 64 function values under a fixed opcode, and compares every output against values the bench derives independently.

// File: rtl/ctl_pkg.sv
package ctl_pkg;

  localparam int OP_W    = 6;
  localparam int FN_W    = 6;
  localparam int ACLS_W  = 3;
  localparam int ACTL_W  = 3;

  localparam logic [OP_W-1:0] OPC_RREG  = 6'b000000;
  localparam logic [OP_W-1:0] OPC_ORIMM = 6'b001101;
  localparam logic [OP_W-1:0] OPC_LOAD  = 6'b100011;
  localparam logic [OP_W-1:0] OPC_STORE = 6'b101011;
  localparam logic [OP_W-1:0] OPC_BEQ   = 6'b000100;
  localparam logic [OP_W-1:0] OPC_JMP   = 6'b000010;

  localparam logic [FN_W-1:0] FN_ADD = 6'b100000;
  localparam logic [FN_W-1:0] FN_SUB = 6'b100010;
  localparam logic [FN_W-1:0] FN_AND = 6'b100100;
  localparam logic [FN_W-1:0] FN_OR  = 6'b100101;
  localparam logic [FN_W-1:0] FN_SLT = 6'b101010;

  typedef enum logic [ACLS_W-1:0] {
    ACLS_ADD  = 3'b000,
    ACLS_SUB  = 3'b001,
    ACLS_OR   = 3'b010,
    ACLS_RREG = 3'b100
  } alu_cls_e;

  typedef enum logic [ACTL_W-1:0] {
    ACTL_AND = 3'b000,
    ACTL_OR  = 3'b001,
    ACTL_ADD = 3'b010,
    ACTL_SUB = 3'b110,
    ACTL_SLT = 3'b111
  } alu_ctl_e;

  typedef struct packed {
    logic     dst_rd;
    logic     src_imm;
    logic     load_to_reg;
    logic     reg_we;
    logic     mem_we;
    logic     branch;
    logic     jump;
    logic     ext_signed;
    alu_cls_e cls;
  } steer_t;

endpackage

// File: rtl/ctl_main_dec.sv
module ctl_main_dec
  import ctl_pkg::*;
(
  input  logic [OP_W-1:0] op_code,
  output steer_t          steer
);

  logic known;

  always_comb begin
    steer             = '0;
    steer.ext_signed  = 1'b1;
    steer.cls         = ACLS_ADD;
    case (op_code)
      OPC_RREG: begin
        steer.dst_rd = 1'b1;
        steer.reg_we = 1'b1;
        steer.cls    = ACLS_RREG;
      end
      OPC_ORIMM: begin
        steer.src_imm    = 1'b1;
        steer.reg_we     = 1'b1;
        steer.ext_signed = 1'b0;
        steer.cls        = ACLS_OR;
      end
      OPC_LOAD: begin
        steer.src_imm     = 1'b1;
        steer.load_to_reg = 1'b1;
        steer.reg_we      = 1'b1;
      end
      OPC_STORE: begin
        steer.src_imm = 1'b1;
        steer.mem_we  = 1'b1;
      end
      OPC_BEQ: begin
        steer.branch = 1'b1;
        steer.cls    = ACLS_SUB;
      end
      OPC_JMP: begin
        steer.jump = 1'b1;
      end
      default: ;
    endcase

    known = (op_code == OPC_RREG)  || (op_code == OPC_ORIMM) ||
            (op_code == OPC_LOAD)  || (op_code == OPC_STORE) ||
            (op_code == OPC_BEQ)   || (op_code == OPC_JMP);

    AST_MEM_REG_EXCL: assert (!(steer.mem_we && steer.reg_we)) else $error("store also writes register"); // R2
    AST_LOAD_PATH: assert (!steer.load_to_reg || (steer.reg_we && steer.src_imm)) else $error("load path incomplete"); // R2
    AST_BR_JMP_EXCL: assert (!(steer.branch && steer.jump)) else $error("branch and jump together"); // R5
    AST_UNKNOWN_QUIET: assert (known || (!steer.reg_we && !steer.mem_we)) else $error("unknown opcode writes"); // R10
    AST_ZEXT_ONLY_ORIMM: assert (steer.ext_signed || (op_code == OPC_ORIMM)) else $error("zero-extend on wrong opcode"); // R4
  end

endmodule

// File: rtl/ctl_alu_dec.sv
module ctl_alu_dec
  import ctl_pkg::*;
(
  input  alu_cls_e        cls,
  input  logic [FN_W-1:0] fn_code,
  output alu_ctl_e        ctl
);

  always_comb begin
    case (cls)
      ACLS_RREG: begin
        case (fn_code)
          FN_ADD:  ctl = ACTL_ADD;
          FN_SUB:  ctl = ACTL_SUB;
          FN_AND:  ctl = ACTL_AND;
          FN_OR:   ctl = ACTL_OR;
          FN_SLT:  ctl = ACTL_SLT;
          default: ctl = ACTL_ADD;
        endcase
      end
      ACLS_OR:  ctl = ACTL_OR;
      ACLS_SUB: ctl = ACTL_SUB;
      default:  ctl = ACTL_ADD;
    endcase

    AST_CTL_LEGAL: assert (ctl != 3'b011 && ctl != 3'b100 && ctl != 3'b101) else $error("illegal ALU code"); // R7
    AST_NONREG_NO_LOGIC: assert (cls == ACLS_RREG || (ctl != ACTL_AND && ctl != ACTL_SLT)) else $error("funct leaked"); // R9
    AST_SUB_CLASS: assert (cls != ACLS_SUB || ctl == ACTL_SUB) else $error("subtract class lost"); // R6
  end

endmodule

// File: rtl/opctl_decoder.sv
module opctl_decoder
  import ctl_pkg::*;
(
  input  logic [OP_W-1:0]   op_code,
  input  logic [FN_W-1:0]   fn_code,
  output logic              dst_rd,
  output logic              src_imm,
  output logic              load_to_reg,
  output logic              reg_we,
  output logic              mem_we,
  output logic              branch,
  output logic              jump,
  output logic              ext_signed,
  output logic [ACTL_W-1:0] alu_ctl
);

  steer_t   steer;
  alu_ctl_e ctl;

  ctl_main_dec u_main (
    .op_code (op_code),
    .steer   (steer)
  );

  ctl_alu_dec u_alu (
    .cls     (steer.cls),
    .fn_code (fn_code),
    .ctl     (ctl)
  );

  assign dst_rd      = steer.dst_rd;
  assign src_imm     = steer.src_imm;
  assign load_to_reg = steer.load_to_reg;
  assign reg_we      = steer.reg_we;
  assign mem_we      = steer.mem_we;
  assign branch      = steer.branch;
  assign jump        = steer.jump;
  assign ext_signed  = steer.ext_signed;
  assign alu_ctl     = ctl;

endmodule

// File: tb/opctl_decoder_bench.sv
module opctl_decoder_bench;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic [5:0] op_code, fn_code;
  logic dst_rd, src_imm, load_to_reg, reg_we, mem_we, branch, jump, ext_signed;
  logic [2:0] alu_ctl;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  opctl_decoder u_opctl_decoder (
    .op_code(op_code), .fn_code(fn_code), .dst_rd(dst_rd), .src_imm(src_imm),
    .load_to_reg(load_to_reg), .reg_we(reg_we), .mem_we(mem_we), .branch(branch),
    .jump(jump), .ext_signed(ext_signed), .alu_ctl(alu_ctl)
  );

  // expected word: {dst,src,ltr,rwe,mwe,br,jmp,ext,alu[2:0]}
  typedef struct packed {
    logic [5:0]  op;
    logic [5:0]  fn;
    logic [10:0] exp;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VECS [NV] = '{
    '{6'h00, 6'h20, 11'b1001_0001_010, 8'd7},  // R7 add
    '{6'h00, 6'h22, 11'b1001_0001_110, 8'd7},  // R7 sub
    '{6'h00, 6'h24, 11'b1001_0001_000, 8'd7},  // R7 and
    '{6'h00, 6'h25, 11'b1001_0001_001, 8'd7},  // R7 or
    '{6'h00, 6'h2A, 11'b1001_0001_111, 8'd7},  // R7 slt
    '{6'h00, 6'h3F, 11'b1001_0001_010, 8'd8},  // R8 unknown funct
    '{6'h00, 6'h2B, 11'b1001_0001_010, 8'd8},  // R8 unknown funct
    '{6'h0D, 6'h00, 11'b0101_0000_001, 8'd4},  // R4 R3 R6 or-immediate
    '{6'h0D, 6'h22, 11'b0101_0000_001, 8'd9},  // R9 funct ignored
    '{6'h23, 6'h00, 11'b0111_0001_010, 8'd2},  // R1 R2 load
    '{6'h2B, 6'h2A, 11'b0100_1001_010, 8'd2},  // R2 R3 store
    '{6'h04, 6'h00, 11'b0000_0101_110, 8'd5},  // R5 R6 beq
    '{6'h04, 6'h25, 11'b0000_0101_110, 8'd9},  // R9 beq ignores funct
    '{6'h02, 6'h24, 11'b0000_0011_010, 8'd5},  // R5 jump
    '{6'h3F, 6'h20, 11'b0000_0001_010, 8'd10}, // R10 unsupported
    '{6'h01, 6'h2A, 11'b0000_0001_010, 8'd10}  // R10 unsupported
  };

  function automatic logic [10:0] ports_word();
    return {dst_rd, src_imm, load_to_reg, reg_we, mem_we, branch, jump, ext_signed, alu_ctl};
  endfunction

  function automatic logic [10:0] model(input logic [5:0] op);
    case (op)
      6'h00:   return 11'b1001_0001_010;  // funct fixed to add by caller
      6'h0D:   return 11'b0101_0000_001;
      6'h23:   return 11'b0111_0001_010;
      6'h2B:   return 11'b0100_1001_010;
      6'h04:   return 11'b0000_0101_110;
      6'h02:   return 11'b0000_0011_010;
      default: return 11'b0000_0001_010;
    endcase
  endfunction

  task automatic check(input logic [10:0] exp, input int req, input string what);
    logic [10:0] act;
    act = ports_word();
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL R%0d %s: actual=%b expected=%b", req, what, act, exp);
    end
  endtask

  task automatic apply(input logic [5:0] op, input logic [5:0] fn);
    @(posedge clk);
    op_code = op;
    fn_code = fn;
    @(negedge clk);
  endtask

  initial begin
    op_code = '0;
    fn_code = '0;
    // idle state check: all-zero inputs decode as register-register and-less add? fn=0 is unknown funct
    @(negedge clk);
    check(11'b1001_0001_010, 8, "R8 idle zero inputs");

    for (int i = 0; i < NV; i++) begin
      apply(VECS[i].op, VECS[i].fn);
      check(VECS[i].exp, int'(VECS[i].req), $sformatf("vector %0d", i));
    end

    // R1 R10 sweep of every opcode with add funct
    for (int o = 0; o < 64; o++) begin
      apply(6'(o), 6'h20);
      check(model(6'(o)), 10, $sformatf("R10 opcode sweep op=%0h", o));
    end

    // R9 sweep of every funct under store
    for (int f = 0; f < 64; f++) begin
      apply(6'h2B, 6'(f));
      check(11'b0100_1001_010, 9, $sformatf("R9 funct sweep fn=%0h", f));
    end

    // R8 funct sweep under register-register, unrecognised values give add
    for (int f = 0; f < 64; f++) begin
      logic [2:0] e;
      apply(6'h00, 6'(f));
      case (6'(f))
        6'h22: e = 3'b110;
        6'h24: e = 3'b000;
        6'h25: e = 3'b001;
        6'h2A: e = 3'b111;
        default: e = 3'b010;
      endcase
      check({8'b1001_0001, e}, 8, $sformatf("R8 rreg funct fn=%0h", f));
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule